// File: doc/BRIEF.md
# Aligning Carry-Save Accumulator

This block keeps a running total in redundant form as two W-bit vectors, a sum word and a carry word, whose arithmetic sum is the accumulated value. Each accepted input word is folded in by one row of full adders, so no carry ripples while values are being added. A product that is already in redundant form is added in two consecutive cycles: its sum word first, then its carry word.

When the running total must be moved to a larger exponent, the controller loads or increases an alignment count. While that count is non-zero, the accumulator feeds both of its vectors back one bit position lower. It decrements the count by one per cycle and can accept a new word in the same cycle. A warning flag reports when the top bit of either stored vector is set, so that the controller can raise the exponent before a carry is lost.

At the end of a sequence, a finish strobe starts a settle phase of W cycles. During that phase, carries move one place per cycle until the carry word is zero, the sum word holds the plain binary total, and a one-cycle strobe presents that total on a result port. New words and count commands are not accepted during this phase.

Top module: `csacc_align_acc`

## Requirements
- R1: With the alignment count at zero and no settle phase running, an accepted word (`add_vld`=1) makes the new (sum+carry) mod 2^W equal the old (sum+carry)+word mod 2^W, and the carry word's bit 0 is always 0. With `add_vld`=0 and nothing else pending, both vectors hold their values.
- R2: With the alignment count non-zero, the new (sum+carry) mod 2^W equals floor(sum/2)+floor(carry/2)+word, where word is 0 if `add_vld`=0. The count drops by one unless a command overrides it.
- R3: `cnt_op` uses 2'b00 to hold, 2'b01 to load `cnt_val`, and 2'b10 to add `cnt_val`; 2'b11 behaves as hold. An add is applied on top of the same cycle's decrement and saturates at 2^CW-1. A load replaces the decremented value. The new count appears on `align_cnt` one cycle after the command.
- R4: A product is added as two words on consecutive cycles, its sum word and then its carry word, and the total increases by their sum.
- R5: `ovf_warn` is 1 exactly when bit W-1 of `sum_o` or of `carry_o` is 1.
- R6: A `finish` pulse while idle raises `busy` on the next cycle for exactly W cycles. In the finish cycle and during `busy`, `add_vld` and `cnt_op` have no effect, the alignment count is frozen, and (sum+carry) mod 2^W is unchanged.
- R7: When `busy` falls, `res_vld` pulses for one cycle with `result` equal to the (sum+carry) mod 2^W that held at finish. At the same time `carry_o` is 0 and `sum_o` equals `result`.
- R8: After synchronous reset, the sum word, carry word, count, `busy`, `res_vld`, `result` and `ovf_warn` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| add_vld | input | 1 | Accept `add_word` this cycle |
| add_word | input | W | Binary word to fold into the total |
| cnt_op | input | 2 | Alignment count command: hold, load, add |
| cnt_val | input | CW | Operand of the count command |
| finish | input | 1 | Start the settle phase |
| sum_o | output | W | Stored sum vector |
| carry_o | output | W | Stored carry vector |
| align_cnt | output | CW | Pending right-shift count |
| ovf_warn | output | 1 | Top bit of either vector is set |
| busy | output | 1 | Settle phase running |
| res_vld | output | 1 | One-cycle strobe for `result` |
| result | output | W | Settled binary total |

## Verification
Every input is registered at one clock edge. The vectors, the count and `ovf_warn` therefore reflect a stimulus one edge later, and the bench compares them at the falling edge that follows. `busy` rises one edge after `finish`, `res_vld` and `result` appear W edges after that, and the bench tracks the settle phase with its own down-counter so that each strobe is expected in exactly that cycle. The expected value is computed from the sampled ports with the integer rules of R1 and R2, and an independent integer total is compared against `result` at the end.

// File: rtl/csacc_pkg.sv
package csacc_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'b00,
    CNT_LOAD = 2'b01,
    CNT_ADD  = 2'b10,
    CNT_RSVD = 2'b11
  } cnt_op_e;
endpackage

// File: rtl/csacc_csa_row.sv
module csacc_csa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] sum_q,
  input  logic [W-1:0] carry_q,
  input  logic [W-1:0] addend,
  input  logic         shift,
  output logic [W-1:0] sum_d,
  output logic [W-1:0] carry_d
);
  logic [W-1:0] a_in;
  logic [W-1:0] b_in;
  logic [W-1:0] maj;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W-1) begin : g_top
      assign a_in[i] = shift ? 1'b0 : sum_q[i];
      assign b_in[i] = shift ? 1'b0 : carry_q[i];
    end else begin : g_mid
      assign a_in[i] = shift ? sum_q[i+1]   : sum_q[i];
      assign b_in[i] = shift ? carry_q[i+1] : carry_q[i];
    end
    assign sum_d[i] = a_in[i] ^ b_in[i] ^ addend[i];
    assign maj[i]   = (a_in[i] & b_in[i]) | (a_in[i] & addend[i]) | (b_in[i] & addend[i]);
  end

  assign carry_d = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/csacc_align_cnt.sv
module csacc_align_cnt
  import csacc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          freeze,
  input  logic [1:0]    op,
  input  logic [CW-1:0] val,
  output logic [CW-1:0] cnt,
  output logic          shift_now
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] base;
  logic [CW:0]   widened;
  logic [CW-1:0] nxt;

  assign shift_now = (cnt != '0) && !freeze;
  assign base      = shift_now ? cnt - 1'b1 : cnt;
  assign widened   = {1'b0, base} + {1'b0, val};

  always_comb begin
    nxt = base;
    case (cnt_op_e'(op))
      CNT_LOAD: nxt = val;
      CNT_ADD:  nxt = widened[CW] ? CMAX : widened[CW-1:0];
      default:  nxt = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (!freeze) cnt <= nxt;
  end
endmodule

// File: rtl/csacc_drain_ctl.sv
module csacc_drain_ctl #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic finish,
  output logic busy,
  output logic last
);
  localparam int DW = $clog2(W) + 1;
  localparam logic [DW-1:0] START = DW'(W - 1);

  logic [DW-1:0] left;

  assign last = busy && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (!busy) begin
      if (finish) begin
        busy <= 1'b1;
        left <= START;
      end
    end else if (left == '0) begin
      busy <= 1'b0;
    end else begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/csacc_align_acc.sv
module csacc_align_acc #(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add_vld,
  input  logic [W-1:0]  add_word,
  input  logic [1:0]    cnt_op,
  input  logic [CW-1:0] cnt_val,
  input  logic          finish,
  output logic [W-1:0]  sum_o,
  output logic [W-1:0]  carry_o,
  output logic [CW-1:0] align_cnt,
  output logic          ovf_warn,
  output logic          busy,
  output logic          res_vld,
  output logic [W-1:0]  result
);
  logic          freeze;
  logic          shift_now;
  logic          take_word;
  logic          step_en;
  logic          last;
  logic [W-1:0]  addend;
  logic [W-1:0]  sum_d;
  logic [W-1:0]  carry_d;

  assign freeze    = busy || finish;
  assign take_word = add_vld && !freeze;
  assign addend    = take_word ? add_word : '0;
  assign step_en   = take_word || shift_now || busy;

  csacc_align_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .freeze   (freeze),
    .op       (cnt_op),
    .val      (cnt_val),
    .cnt      (align_cnt),
    .shift_now(shift_now)
  );

  csacc_csa_row #(.W(W)) u_row (
    .sum_q  (sum_o),
    .carry_q(carry_o),
    .addend (addend),
    .shift  (shift_now),
    .sum_d  (sum_d),
    .carry_d(carry_d)
  );

  csacc_drain_ctl #(.W(W)) u_drain (
    .clk   (clk),
    .rst   (rst),
    .finish(finish),
    .busy  (busy),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o    <= '0;
      carry_o  <= '0;
      ovf_warn <= 1'b0;
      res_vld  <= 1'b0;
      result   <= '0;
    end else begin
      res_vld <= last;
      if (step_en) begin
        sum_o    <= sum_d;
        carry_o  <= carry_d;
        ovf_warn <= sum_d[W-1] | carry_d[W-1];
      end
      if (last) result <= sum_d;
    end
  end
endmodule

// File: rtl/csacc_chk.sv
module csacc_chk #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          add_vld,
  input logic [1:0]    cnt_op,
  input logic [CW-1:0] cnt_val,
  input logic          finish,
  input logic [W-1:0]  sum_o,
  input logic [W-1:0]  carry_o,
  input logic [CW-1:0] align_cnt,
  input logic          ovf_warn,
  input logic          busy,
  input logic          res_vld,
  input logic [W-1:0]  result
);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!add_vld && align_cnt == '0 && !busy) |=> ($stable(sum_o) && $stable(carry_o)));

  assert_shift_dec_R2: assert property (@(posedge clk) disable iff (rst)
    (align_cnt != '0 && !busy && !finish && cnt_op == 2'b00) |=> (align_cnt == $past(align_cnt) - 1'b1));

  assert_cnt_load_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_op == 2'b01 && !busy && !finish) |=> (align_cnt == $past(cnt_val)));

  assert_warn_top_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_warn == (sum_o[W-1] | carry_o[W-1]));

  assert_cnt_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(align_cnt));

  assert_settled_R7: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (carry_o == '0 && result == sum_o && !busy));

  assert_strobe_one_R7: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> !res_vld);
endmodule

bind csacc_align_acc csacc_chk #(.W(W), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .add_vld  (add_vld),
  .cnt_op   (cnt_op),
  .cnt_val  (cnt_val),
  .finish   (finish),
  .sum_o    (sum_o),
  .carry_o  (carry_o),
  .align_cnt(align_cnt),
  .ovf_warn (ovf_warn),
  .busy     (busy),
  .res_vld  (res_vld),
  .result   (result)
);

// File: tb/test_csacc_align_acc.sv
module test_csacc_align_acc;
  localparam int W    = 16;
  localparam int CW   = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          add_vld = 1'b0;
  logic [W-1:0]  add_word = '0;
  logic [1:0]    cnt_op = 2'b00;
  logic [CW-1:0] cnt_val = '0;
  logic          finish = 1'b0;
  logic [W-1:0]  sum_o;
  logic [W-1:0]  carry_o;
  logic [CW-1:0] align_cnt;
  logic          ovf_warn;
  logic          busy;
  logic          res_vld;
  logic [W-1:0]  result;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int m_left = 0;
  bit m_busy = 1'b0;
  int ref_sum = 0;

  always #10 clk = ~clk;

  csacc_align_acc #(.W(W), .CW(CW)) i_csacc_align_acc (
    .clk(clk), .rst(rst), .add_vld(add_vld), .add_word(add_word),
    .cnt_op(cnt_op), .cnt_val(cnt_val), .finish(finish),
    .sum_o(sum_o), .carry_o(carry_o), .align_cnt(align_cnt),
    .ovf_warn(ovf_warn), .busy(busy), .res_vld(res_vld), .result(result)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(input bit v, input int x, input int op, input int val, input bit fin);
    int s0 = int'(sum_o);
    int c0 = int'(carry_o);
    int k0 = int'(align_cnt);
    int ev;
    int ek;
    bit frozen = m_busy || fin;
    bit ends = 1'b0;
    add_vld = v; add_word = W'(x); cnt_op = 2'(op); cnt_val = CW'(val); finish = fin;
    if (frozen) begin
      ev = (s0 + c0) & MASK;
      ek = k0;
    end else if (k0 != 0) begin
      ev = ((s0 >> 1) + (c0 >> 1) + (v ? x : 0)) & MASK;
      ek = k0 - 1;
    end else begin
      ev = (s0 + c0 + (v ? x : 0)) & MASK;
      ek = k0;
    end
    if (!frozen) begin
      if (op == 1) ek = val;
      else if (op == 2) ek = (ek + val > CMAX) ? CMAX : ek + val;
    end
    if (m_busy) begin
      m_left--;
      if (m_left == 0) begin m_busy = 1'b0; ends = 1'b1; end
    end else if (fin) begin
      m_busy = 1'b1; m_left = W;
    end
    @(posedge clk);
    @(negedge clk);
    add_vld = 1'b0; cnt_op = 2'b00; finish = 1'b0;
    if (frozen) check("R6 value", (int'(sum_o) + int'(carry_o)) & MASK, ev);
    else if (k0 != 0) check("R2 value", (int'(sum_o) + int'(carry_o)) & MASK, ev);
    else check("R1 value", (int'(sum_o) + int'(carry_o)) & MASK, ev);
    check("R1 carry lsb", int'(carry_o[0]), 0);
    check(frozen ? "R6 count" : "R3 count", int'(align_cnt), ek);
    check("R5 warn", int'(ovf_warn), int'(sum_o[W-1] | carry_o[W-1]));
    check("R6 busy", int'(busy), int'(m_busy));
    check("R7 strobe", int'(res_vld), int'(ends));
    if (ends) begin
      check("R7 result", int'(result), ev);
      check("R7 carry zero", int'(carry_o), 0);
      check("R7 sum binary", int'(sum_o), ev);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_busy = 1'b0; m_left = 0; ref_sum = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    do_reset();
    // R8: reset state
    check("R8 sum", int'(sum_o), 0);
    check("R8 carry", int'(carry_o), 0);
    check("R8 count", int'(align_cnt), 0);
    check("R8 busy", int'(busy), 0);
    check("R8 strobe", int'(res_vld), 0);
    check("R8 result", int'(result), 0);
    check("R8 warn", int'(ovf_warn), 0);

    // R1: plain adds, idle cycles hold
    step(1, 16'h0123, 0, 0, 0); ref_sum += 16'h0123;
    step(1, 16'h0fff, 0, 0, 0); ref_sum += 16'h0fff;
    step(0, 16'h7777, 0, 0, 0);
    step(1, 16'h0555, 0, 0, 0); ref_sum += 16'h0555;
    step(1, 16'h0aaa, 0, 0, 0); ref_sum += 16'h0aaa;
    // R4: product as sum word then carry word
    step(1, 16'h0a5a, 0, 0, 0); ref_sum += 16'h0a5a;
    step(1, 16'h05a4, 0, 0, 0); ref_sum += 16'h05a4;
    // R6/R7: settle and compare with integer total
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < W; i++) step(1, 16'h00ff, 1, 5, 0);
    check("R7 integer total", int'(result), ref_sum & MASK);
    check("R4 product total", int'(sum_o), ref_sum & MASK);
    step(0, 0, 0, 0, 0);

    // R2/R3: shifts with and without adds
    do_reset();
    step(1, 16'h3c3c, 0, 0, 0);
    step(1, 16'h1111, 0, 0, 0);
    step(0, 0, 1, 3, 0);
    step(0, 0, 0, 0, 0);
    step(1, 16'h0707, 0, 0, 0);
    step(1, 16'h0101, 0, 0, 0);
    step(1, 16'h0202, 0, 0, 0);
    // R3: add on top of decrement, saturation, load override, reserved code
    step(0, 0, 1, 12, 0);
    step(0, 0, 2, 10, 0);
    step(0, 0, 3, 9, 0);
    step(0, 0, 1, 2, 0);
    step(0, 0, 2, 1, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);

    // R5: warning on top bit, cleared by a realignment
    do_reset();
    step(1, 16'h8000, 0, 0, 0);
    check("R5 warn raised", int'(ovf_warn), 1);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0);
    check("R5 warn cleared", int'(ovf_warn), 0);
    step(1, 16'h6000, 0, 0, 0);
    step(1, 16'h3000, 0, 0, 0);

    // R6: settle while a shift is pending; count stays frozen
    step(0, 0, 1, 4, 0);
    step(1, 16'h0010, 2, 3, 1);
    for (int i = 0; i < W; i++) step(1, 16'h1234, 2, 7, (i == 3));
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    summary();
  end
endmodule